// File: doc/BRIEF.md
# Per-Channel Over-Current Guard

This block protects the outputs of a multi-channel drive card. Each channel supplies a raw one-bit over-current indication. A fault only counts once that indication has stayed high for a programmable number of clock ticks. When a fault counts, the block sets a sticky status bit for the channel. Unless protection has been switched off, it also drops that channel's output enable on the next clock.

Software reaches the block through a small register port with four word addresses. One address holds the protection override, and one holds the status, which clears when read. The other two are commands. The retry command re-enables a chosen set of channels. The reset command re-enables every channel and clears all detection state. Reading the status never turns an output back on. While the card runs its off-line self-test, monitoring is suspended.

Top module: `ocp_guard`

## Requirements
- R1: After reset every output enable is 1, the status reads 0 and the override bit reads 0.
- R2: Address 0 holds the override in bit 0, readable back. While it is 1, a qualified fault latches status but does not drop an output. While it is 0, protection is active.
- R3: A channel's fault is qualified once its raw input has been sampled high on QUAL_TICKS consecutive clock edges. Its status bit is set on the following edge.
- R4: Reading address 1 returns the status with channel i in bit i (a 1 meaning over-current). The bits above the channel count read 0.
- R5: A status read returns the value before the read and then clears it. If a fault is still qualified at the read edge, the bit stays set.
- R6: Neither a status read nor the dropping of the raw input turns a disabled output back on.
- R7: A channel's output enable goes low on the edge after its fault is qualified, provided the override is 0 at that edge.
- R8: A write to address 2 re-enables each channel whose bit is set in the write data. A channel that is still qualified at that edge stays disabled.
- R9: A write to address 3 re-enables all channels, clears the status and restarts every qualification count from zero.
- R10: While the self-test input is high, the qualification counts are held at zero, and no status bit is set and no output dropped.
- R11: If the raw input goes low before the window completes, the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| oc_raw | input | NUM_CH | Raw over-current indication per channel |
| selftest_active | input | 1 | Off-line self-test running; suspends monitoring |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | REG_DW | Write data |
| reg_rdata | output | REG_DW | Read data, valid the cycle after the read strobe |
| out_en | output | NUM_CH | Output enable per channel |

## Verification
Raw inputs are driven as steady holds that just reach the window and as pulses one tick short of it, separated by a single low sample. These separate a correct consecutive-sample count from an off-by-one or from a count that merely accumulates. Faults on single channels and on channel pairs show that the bit placement is right and that channels do not interact. Retry and reset are issued both with the fault gone and with it still present, so the priority between restoring and disabling is exposed. A read is also made while the fault is still qualified, and self-test is held across several windows, to catch a clear that wins over a set and a qualification that runs while self-test is active.

// File: rtl/ocp_pkg.sv
// Package: shared register map and constants for the over-current guard.
// Assumes a word-addressed register port of two address bits.
package ocp_pkg;
    localparam int REG_DW = 16;

    typedef enum logic [1:0] {
        ADDR_OVERRIDE = 2'd0,
        ADDR_STATUS   = 2'd1,
        ADDR_RETRY    = 2'd2,
        ADDR_RESTORE  = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/ocp_qualifier.sv
// Module: qualifies one channel's raw over-current input over a window.
// The qualified output is high while the input has been sampled high on
// QUAL_TICKS consecutive edges. The count is held at zero while hold is
// high and is cleared by restart. Assumes the raw input is synchronous.
module ocp_qualifier #(
    parameter int QUAL_TICKS = 125_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic hold,
    input  logic restart,
    output logic qualified
);
    localparam int CW = $clog2(QUAL_TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(QUAL_TICKS);

    logic [CW-1:0] cnt_q;

    // Count consecutive high samples, saturating at the window length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (hold || restart || !raw) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The window is complete once the saturation value is reached.
    always_comb begin
        qualified = (cnt_q == LIMIT);
    end
endmodule

// File: rtl/ocp_regs.sv
// Module: register port of the guard. Holds the override bit, decodes the
// retry and restore commands into single-cycle controls, and returns read
// data one cycle after the read strobe. Assumes reads and writes do not
// target the same address in one cycle.
module ocp_regs
    import ocp_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DW     = REG_DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    input  logic [NUM_CH-1:0] status,
    output logic              override,
    output logic [NUM_CH-1:0] retry_mask,
    output logic              restore_all,
    output logic              status_clear,
    output logic [DW-1:0]     reg_rdata
);
    logic          ovr_q;
    logic [DW-1:0] rdata_q;
    logic [DW-1:0] rdata_d;
    logic          unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[DW-1:NUM_CH];

    // Hold the protection override bit written at its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if (reg_wr && reg_addr == ADDR_OVERRIDE) begin
            ovr_q <= reg_wdata[0];
        end
    end

    // Decode command writes and the read-clear strobe.
    always_comb begin
        retry_mask   = (reg_wr && reg_addr == ADDR_RETRY) ? reg_wdata[NUM_CH-1:0] : '0;
        restore_all  = reg_wr && reg_addr == ADDR_RESTORE;
        status_clear = reg_rd && reg_addr == ADDR_STATUS;
    end

    // Select the read value for the addressed register.
    always_comb begin
        rdata_d = '0;
        case (reg_addr)
            ADDR_OVERRIDE: rdata_d[0] = ovr_q;
            ADDR_STATUS:   rdata_d[NUM_CH-1:0] = status;
            default:       rdata_d = '0;
        endcase
    end

    // Register the read value on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (reg_rd) begin
            rdata_q <= rdata_d;
        end
    end

    assign override  = ovr_q;
    assign reg_rdata = rdata_q;
endmodule

// File: rtl/ocp_latch.sv
// Module: sticky status and output enables for all channels. A qualified
// fault sets status and, unless overridden, clears the enable. A read clear
// loses to a set in the same cycle. The enable comes back only on retry or
// restore. Restore has the highest priority.
module ocp_latch #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] qual,
    input  logic              override,
    input  logic [NUM_CH-1:0] retry_mask,
    input  logic              restore_all,
    input  logic              status_clear,
    output logic [NUM_CH-1:0] status,
    output logic [NUM_CH-1:0] out_en
);
    logic [NUM_CH-1:0] status_q;
    logic [NUM_CH-1:0] en_q;
    logic [NUM_CH-1:0] trip;

    // Faults that remove an output this cycle.
    always_comb begin
        trip = override ? '0 : qual;
    end

    // Sticky status: set by a fault, cleared by a read or a restore.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else if (restore_all) begin
            status_q <= '0;
        end else begin
            status_q <= (status_clear ? '0 : status_q) | qual;
        end
    end

    // Output enables: a trip beats a retry, and a restore beats both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '1;
        end else if (restore_all) begin
            en_q <= '1;
        end else begin
            en_q <= (en_q | retry_mask) & ~trip;
        end
    end

    assign status = status_q;
    assign out_en = en_q;
endmodule

// File: rtl/ocp_guard.sv
// Module: top of the per-channel over-current guard. One qualifier per
// channel feeds the shared status/enable latch. The register port gives
// access to the override, the status and the commands. Assumes all inputs
// are synchronous to clk.
module ocp_guard
    import ocp_pkg::*;
#(
    parameter int NUM_CH     = 4,
    parameter int QUAL_TICKS = 125_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] oc_raw,
    input  logic              selftest_active,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic [NUM_CH-1:0] out_en
);
    logic [NUM_CH-1:0] qual;
    logic [NUM_CH-1:0] status_q;
    logic [NUM_CH-1:0] retry_mask;
    logic              override_q;
    logic              restore_all;
    logic              status_clear;

    // One window qualifier per channel.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        ocp_qualifier #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
            .clk       (clk),
            .rst_n     (rst_n),
            .raw       (oc_raw[ch]),
            .hold      (selftest_active),
            .restart   (restore_all),
            .qualified (qual[ch])
        );
    end

    ocp_regs #(.NUM_CH(NUM_CH), .DW(REG_DW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_rd       (reg_rd),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .status       (status_q),
        .override     (override_q),
        .retry_mask   (retry_mask),
        .restore_all  (restore_all),
        .status_clear (status_clear),
        .reg_rdata    (reg_rdata)
    );

    ocp_latch #(.NUM_CH(NUM_CH)) u_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .qual         (qual),
        .override     (override_q),
        .retry_mask   (retry_mask),
        .restore_all  (restore_all),
        .status_clear (status_clear),
        .status       (status_q),
        .out_en       (out_en)
    );
endmodule

// File: rtl/ocp_guard_chk.sv
// Module: assertion checker bound to the guard top. It observes the ports
// together with the internal status and override registers.
module ocp_guard_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              selftest_active,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [1:0]        reg_addr,
    input logic [15:0]       reg_wdata,
    input logic [NUM_CH-1:0] out_en,
    input logic [NUM_CH-1:0] status_q,
    input logic              override_q
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        // R6/R8/R9: an output only comes back after a retry naming it or a restore.
        p_enable_needs_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(out_en[i]) |->
            $past(reg_wr && ((reg_addr == 2'd2 && reg_wdata[i]) || reg_addr == 2'd3)));

        // R7: an output never drops while the override was set.
        p_trip_needs_protect_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(out_en[i]) |-> !$past(override_q));

        // R5: status clears only through a status read or a restore.
        p_status_clear_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(status_q[i]) |->
            $past((reg_rd && reg_addr == 2'd1) || (reg_wr && reg_addr == 2'd3)));
    end

    // R10: no status bit appears one cycle after self-test was seen active.
    p_selftest_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(selftest_active) |-> ((status_q & ~$past(status_q)) == '0));
endmodule

bind ocp_guard ocp_guard_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/tb_ocp_guard.sv
module tb_ocp_guard;
    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  oc_raw = '0;
    logic        selftest_active = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [3:0]  out_en;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ocp_guard #(.NUM_CH(4), .QUAL_TICKS(Q)) dut (
        .clk(clk), .rst_n(rst_n), .oc_raw(oc_raw), .selftest_active(selftest_active),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .out_en(out_en)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step(1);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_rd = 1'b1; reg_addr = a;
        step(1);
        d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic restore();
        oc_raw = '0; selftest_active = 1'b0;
        wr(2'd3, 16'h0);
        step(1);
    endtask

    task automatic t_reset_state();
        logic [15:0] d;
        chk("R1 enables", {12'h0, out_en}, 16'h000F);
        rd(2'd1, d); chk("R1 status", d, 16'h0000);
        rd(2'd0, d); chk("R1 override", d, 16'h0000);
    endtask

    task automatic t_qualify();
        logic [15:0] d;
        oc_raw[2] = 1'b1;
        step(Q);
        chk("R3 not before window", {12'h0, out_en}, 16'h000F);
        step(1);
        chk("R7 trip after window", {12'h0, out_en}, 16'h000B);
        oc_raw = '0;
        step(1);
        rd(2'd1, d); chk("R4 channel 2 in bit 2", d, 16'h0004);
        restore();
        oc_raw[0] = 1'b1;
        step(Q + 1);
        oc_raw = '0;
        step(1);
        rd(2'd1, d); chk("R4 channel 0 in bit 0", d, 16'h0001);
        restore();
    endtask

    task automatic t_restart();
        logic [15:0] d;
        oc_raw[0] = 1'b1; step(Q - 1);
        oc_raw[0] = 1'b0; step(1);
        oc_raw[0] = 1'b1; step(Q - 1);
        oc_raw[0] = 1'b0; step(2);
        chk("R11 short pulses keep enable", {12'h0, out_en}, 16'h000F);
        rd(2'd1, d); chk("R11 short pulses no status", d, 16'h0000);
        restore();
    endtask

    task automatic t_read_clear();
        logic [15:0] d;
        oc_raw[1] = 1'b1; step(Q + 1);
        oc_raw = '0; step(1);
        rd(2'd1, d); chk("R5 read returns set bit", d, 16'h0002);
        rd(2'd1, d); chk("R5 read cleared", d, 16'h0000);
        chk("R6 read does not re-enable", {12'h0, out_en}, 16'h000D);
        restore();
    endtask

    task automatic t_collision();
        logic [15:0] d;
        oc_raw[3] = 1'b1; step(Q + 1);
        rd(2'd1, d); chk("R5 first read", d, 16'h0008);
        rd(2'd1, d); chk("R5 set beats clear", d, 16'h0008);
        oc_raw = '0; step(1);
        rd(2'd1, d); chk("R5 last set read", d, 16'h0008);
        rd(2'd1, d); chk("R5 clear after fault gone", d, 16'h0000);
        chk("R6 still disabled", {12'h0, out_en}, 16'h0007);
        restore();
    endtask

    task automatic t_retry();
        oc_raw = 4'h3; step(Q + 1);
        chk("R7 two channels tripped", {12'h0, out_en}, 16'h000C);
        oc_raw[1] = 1'b0; step(1);
        wr(2'd2, 16'h0003);
        chk("R8 retry, live fault stays off", {12'h0, out_en}, 16'h000E);
        oc_raw[0] = 1'b0; step(1);
        wr(2'd2, 16'h0002);
        chk("R8 unmasked channel stays off", {12'h0, out_en}, 16'h000E);
        wr(2'd2, 16'h0001);
        chk("R8 masked retry restores", {12'h0, out_en}, 16'h000F);
        restore();
    endtask

    task automatic t_restore_cmd();
        logic [15:0] d;
        oc_raw = 4'h5; step(Q + 1);
        chk("R7 channels 0 and 2 off", {12'h0, out_en}, 16'h000A);
        wr(2'd3, 16'h0);
        chk("R9 restore enables all", {12'h0, out_en}, 16'h000F);
        rd(2'd1, d); chk("R9 restore clears status", d, 16'h0000);
        step(Q - 1);
        chk("R9 count restarted", {12'h0, out_en}, 16'h000F);
        step(1);
        chk("R9 re-trip after full window", {12'h0, out_en}, 16'h000A);
        restore();
    endtask

    task automatic t_override();
        logic [15:0] d;
        wr(2'd0, 16'h0001);
        rd(2'd0, d); chk("R2 override readback", d, 16'h0001);
        oc_raw[2] = 1'b1; step(Q + 3);
        chk("R2 override keeps output", {12'h0, out_en}, 16'h000F);
        rd(2'd1, d); chk("R2 status still latches", d, 16'h0004);
        wr(2'd0, 16'h0000);
        chk("R7 no trip at override edge", {12'h0, out_en}, 16'h000F);
        step(1);
        chk("R7 trip once protection on", {12'h0, out_en}, 16'h000B);
        rd(2'd0, d); chk("R2 override cleared", d, 16'h0000);
        restore();
    endtask

    task automatic t_selftest();
        logic [15:0] d;
        selftest_active = 1'b1;
        oc_raw = 4'hF; step(3 * Q);
        chk("R10 no trip in self-test", {12'h0, out_en}, 16'h000F);
        rd(2'd1, d); chk("R10 no status in self-test", d, 16'h0000);
        selftest_active = 1'b0;
        step(Q);
        chk("R10 count starts after self-test", {12'h0, out_en}, 16'h000F);
        step(1);
        chk("R10 trip after self-test", {12'h0, out_en}, 16'h0000);
        restore();
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset_state();
        t_qualify();
        t_restart();
        t_read_clear();
        t_collision();
        t_retry();
        t_restore_cmd();
        t_override();
        t_selftest();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule